// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Edge Capture

This block gives software control of a bank of general-purpose pins, a multiple of 32, through a word-wide register port. Each pin has several controls:

- a direction bit;
- an output latch, changed only through separate write-one set and write-one clear words, so no read-modify-write is ever needed;
- a 2-bit alternate-function selector, handed to the pad mux next door.

Pad inputs pass through a two-flop synchronizer. The synchronized values can be read back as a level view. They also feed per-pin rising and falling edge detectors.

Detected edges are held in a sticky status array until software writes ones to it. A single interrupt line is high while any status bit is held. The register groups sit one after another, each `NUM_PINS/32` words long. The alternate-function group is twice as long and sits at the top of the map.

Top module: `gpio_ec_ctrl`

## Requirements
- R1: While reset is held and after reset, the direction, output latches, edge enables, edge status and alternate-function fields are all 0, so `pad_oe`, `pad_out`, `alt_sel` and `irq` read 0.
- R2: Word w of group g sits at byte address g*NREG*4 + w*4, where NREG = NUM_PINS/32. The group order is: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 status, 7 alternate function. Pin p is bit p%32 of word p/32, and address bits [1:0] are ignored.
- R3: A read of the level group returns `pad_in` after two clocks of synchronizer delay. Writes to the level group change nothing.
- R4: A direction bit of 1 makes the pin an output: `pad_oe` follows the direction words, which read back as written.
- R5: A 1 written into a set word drives that pin's `pad_out` latch high. Zero bits leave their latches unchanged, and set words read 0.
- R6: A 1 written into a clear word drives that pin's latch low. Zero bits leave their latches unchanged, and clear words read 0.
- R7: With the pin's rising enable set, a 0-to-1 change of the synchronized input sets its status bit one clock after the level view changes.
- R8: With the pin's falling enable set, a 1-to-0 change sets the status bit. With both enables set, either direction is recorded. A direction that is not enabled records nothing.
- R9: A status bit stays set until a 1 is written to it. Writing all ones clears a whole status word, and zero bits in the write leave their status bits alone.
- R10: If an edge on a pin is detected in the same clock as a write that clears its status bit, the bit stays set.
- R11: `irq` is high exactly while at least one status bit is set.
- R12: Pin p's 2-bit alternate-function field is at bits [2*(p%16)+1 : 2*(p%16)] of alternate-function word p/16. The field reads back as written and drives `alt_sel[2p+1:2p]`. The value 0 means plain GPIO.
- R13: Reads from addresses beyond the alternate-function group return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_out | output | NUM_PINS | Output latch values |
| pad_oe | output | NUM_PINS | Output enables (direction) |
| alt_sel | output | 2*NUM_PINS | Alternate-function selector, 2 bits per pin |
| irq | output | 1 | OR of all edge status bits |

## Verification
The bench walks every pin through set and clear. A design that decoded the wrong bit or word would disturb a neighbour's latch, or drop a pin in the second word.

It raises and lowers every pin under each enable choice. This catches a swapped rise/fall detector, a disabled direction that still records, and status bits that self-clear.

It also times a falling edge so that detection lands on the same clock as a write-one clear of that bit. A design that lets the clear win would lose that edge.

The level view is sampled one and two clocks after an input change to pin down the synchronizer depth. Every alternate-function field gets a computed value, which exposes a wrong 16-pins-per-word packing. An access just past the map confirms it aliases onto no group.

// File: rtl/gpio_ec_pkg.sv
package gpio_ec_pkg;

    localparam int WORD_W      = 32;
    localparam int NUM_STD_GRP = 7;
    localparam int SEL_W       = 8;

    typedef enum logic [3:0] {
        GRP_LEVEL = 4'd0,
        GRP_DIR   = 4'd1,
        GRP_SET   = 4'd2,
        GRP_CLR   = 4'd3,
        GRP_RISE  = 4'd4,
        GRP_FALL  = 4'd5,
        GRP_STAT  = 4'd6,
        GRP_ALT   = 4'd7,
        GRP_NONE  = 4'd15
    } grp_e;

    typedef struct packed {
        grp_e               grp;
        logic [SEL_W-1:0]   sel;
    } dec_t;

endpackage

// File: rtl/gpio_ec_sync.sv
module gpio_ec_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_ec_decode.sv
module gpio_ec_decode
    import gpio_ec_pkg::*;
#(
    parameter int NREG   = 2,
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    localparam int TOTAL_WORDS = (NUM_STD_GRP + 2) * NREG;
    localparam int ALT_BASE    = NUM_STD_GRP * NREG;

    logic [ADDR_W-3:0] widx;
    assign widx = addr[ADDR_W-1:2];

    always_comb begin
        dec.grp = GRP_NONE;
        dec.sel = '0;
        for (int g = 0; g < NUM_STD_GRP; g++) begin
            if (int'(widx) >= g * NREG && int'(widx) < (g + 1) * NREG) begin
                dec.grp = grp_e'(4'(g));
                dec.sel = SEL_W'(int'(widx) - g * NREG);
            end
        end
        if (int'(widx) >= ALT_BASE && int'(widx) < TOTAL_WORDS) begin
            dec.grp = GRP_ALT;
            dec.sel = SEL_W'(int'(widx) - ALT_BASE);
        end
    end

endmodule

// File: rtl/gpio_ec_edge.sv
module gpio_ec_edge #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] status
);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] status_q;
    logic [WIDTH-1:0] hit;

    // A fresh edge is ORed in after the clear, so it outranks a same-cycle clear.
    assign hit = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            status_q <= '0;
        end else begin
            prev_q   <= lvl;
            status_q <= (status_q & ~clr_mask) | hit;
        end
    end

    assign status = status_q;

endmodule

// File: rtl/gpio_ec_ctrl.sv
module gpio_ec_ctrl
    import gpio_ec_pkg::*;
#(
    parameter  int NUM_PINS = 64,
    localparam int NREG     = NUM_PINS / WORD_W,
    localparam int ADDR_W   = $clog2((NUM_STD_GRP + 2) * NREG * 4)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    input  logic                  bus_we,
    output logic [WORD_W-1:0]     bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [2*NUM_PINS-1:0] alt_sel,
    output logic                  irq
);

    localparam int ALT_WORDS = 2 * NREG;

    dec_t                  dec;
    logic [NUM_PINS-1:0]   lvl_sync;
    logic [NUM_PINS-1:0]   dir_q;
    logic [NUM_PINS-1:0]   out_q;
    logic [NUM_PINS-1:0]   rise_q;
    logic [NUM_PINS-1:0]   fall_q;
    logic [NUM_PINS-1:0]   stat_w;
    logic [2*NUM_PINS-1:0] alt_q;

    gpio_ec_decode #(
        .NREG   (NREG),
        .ADDR_W (ADDR_W)
    ) decode_i (
        .addr (bus_addr),
        .dec  (dec)
    );

    gpio_ec_sync #(
        .WIDTH (NUM_PINS)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pad_in),
        .sync_out (lvl_sync)
    );

    for (genvar w = 0; w < NREG; w++) begin : g_word
        localparam logic [SEL_W-1:0] WSEL = SEL_W'(w);

        logic hit_dir, hit_set, hit_clr, hit_rise, hit_fall, hit_stat;
        logic [WORD_W-1:0] clr_mask;

        assign hit_dir  = bus_we && dec.grp == GRP_DIR  && dec.sel == WSEL;
        assign hit_set  = bus_we && dec.grp == GRP_SET  && dec.sel == WSEL;
        assign hit_clr  = bus_we && dec.grp == GRP_CLR  && dec.sel == WSEL;
        assign hit_rise = bus_we && dec.grp == GRP_RISE && dec.sel == WSEL;
        assign hit_fall = bus_we && dec.grp == GRP_FALL && dec.sel == WSEL;
        assign hit_stat = bus_we && dec.grp == GRP_STAT && dec.sel == WSEL;
        assign clr_mask = hit_stat ? bus_wdata : '0;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dir_q[w*WORD_W +: WORD_W]  <= '0;
                out_q[w*WORD_W +: WORD_W]  <= '0;
                rise_q[w*WORD_W +: WORD_W] <= '0;
                fall_q[w*WORD_W +: WORD_W] <= '0;
            end else begin
                if (hit_dir)  dir_q[w*WORD_W +: WORD_W]  <= bus_wdata;
                if (hit_rise) rise_q[w*WORD_W +: WORD_W] <= bus_wdata;
                if (hit_fall) fall_q[w*WORD_W +: WORD_W] <= bus_wdata;
                if (hit_set)
                    out_q[w*WORD_W +: WORD_W] <= out_q[w*WORD_W +: WORD_W] | bus_wdata;
                else if (hit_clr)
                    out_q[w*WORD_W +: WORD_W] <= out_q[w*WORD_W +: WORD_W] & ~bus_wdata;
            end
        end

        gpio_ec_edge #(
            .WIDTH (WORD_W)
        ) edge_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (lvl_sync[w*WORD_W +: WORD_W]),
            .rise_en  (rise_q[w*WORD_W +: WORD_W]),
            .fall_en  (fall_q[w*WORD_W +: WORD_W]),
            .clr_mask (clr_mask),
            .status   (stat_w[w*WORD_W +: WORD_W])
        );
    end

    for (genvar k = 0; k < ALT_WORDS; k++) begin : g_alt
        localparam logic [SEL_W-1:0] KSEL = SEL_W'(k);
        logic hit_alt;
        assign hit_alt = bus_we && dec.grp == GRP_ALT && dec.sel == KSEL;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                alt_q[k*WORD_W +: WORD_W] <= '0;
            else if (hit_alt)
                alt_q[k*WORD_W +: WORD_W] <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (dec.grp)
            GRP_LEVEL: bus_rdata = lvl_sync[int'(dec.sel)*WORD_W +: WORD_W];
            GRP_DIR:   bus_rdata = dir_q[int'(dec.sel)*WORD_W +: WORD_W];
            GRP_RISE:  bus_rdata = rise_q[int'(dec.sel)*WORD_W +: WORD_W];
            GRP_FALL:  bus_rdata = fall_q[int'(dec.sel)*WORD_W +: WORD_W];
            GRP_STAT:  bus_rdata = stat_w[int'(dec.sel)*WORD_W +: WORD_W];
            GRP_ALT:   bus_rdata = alt_q[int'(dec.sel)*WORD_W +: WORD_W];
            default:   bus_rdata = '0;
        endcase
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;
    assign alt_sel = alt_q;
    assign irq     = |stat_w;

endmodule

// File: rtl/gpio_ec_ctrl_chk.sv
module gpio_ec_ctrl_chk #(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [31:0]           bus_wdata,
    input logic                  bus_we,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [2*NUM_PINS-1:0] alt_sel,
    input logic                  irq
);

    localparam int NREG = NUM_PINS / 32;

    localparam logic [2:0] K_NONE = 3'd0;
    localparam logic [2:0] K_DIR  = 3'd1;
    localparam logic [2:0] K_SET  = 3'd2;
    localparam logic [2:0] K_CLR  = 3'd3;
    localparam logic [2:0] K_ALT  = 3'd4;
    localparam logic [2:0] K_LVL  = 3'd5;

    int         widx;
    logic [2:0] kind_now;
    logic [7:0] word_now;
    logic [2:0] pend_kind;
    logic [7:0] pend_w;
    logic [31:0] pend_d;
    logic [31:0] oe_word, out_word, alt_word;

    assign widx = int'(bus_addr) / 4;

    always_comb begin
        kind_now = K_NONE;
        word_now = '0;
        if (bus_we) begin
            if (widx < NREG) begin
                kind_now = K_LVL;
            end else if (widx < 2 * NREG) begin
                kind_now = K_DIR; word_now = 8'(widx - NREG);
            end else if (widx < 3 * NREG) begin
                kind_now = K_SET; word_now = 8'(widx - 2 * NREG);
            end else if (widx < 4 * NREG) begin
                kind_now = K_CLR; word_now = 8'(widx - 3 * NREG);
            end else if (widx >= 7 * NREG && widx < 9 * NREG) begin
                kind_now = K_ALT; word_now = 8'(widx - 7 * NREG);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_kind <= K_NONE;
            pend_w    <= '0;
            pend_d    <= '0;
        end else begin
            pend_kind <= kind_now;
            pend_w    <= word_now;
            pend_d    <= bus_wdata;
        end
    end

    assign oe_word  = pad_oe[int'(pend_w)*32 +: 32];
    assign out_word = pad_out[int'(pend_w)*32 +: 32];
    assign alt_word = alt_sel[int'(pend_w)*32 +: 32];

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_kind == K_DIR) |-> (oe_word == pend_d)); // R4

    AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_kind == K_SET) |-> ((out_word & pend_d) == pend_d)); // R5

    AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_kind == K_CLR) |-> ((out_word & pend_d) == 32'd0)); // R6

    AST_ALT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_kind == K_ALT) |-> (alt_word == pend_d)); // R12

    AST_LEVEL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_now == K_LVL) |=> ($stable(pad_out) && $stable(pad_oe))); // R3

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_we) |=> irq); // R9

endmodule

bind gpio_ec_ctrl gpio_ec_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .alt_sel   (alt_sel),
    .irq       (irq)
);

// File: tb/gpio_ec_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_ec_ctrl_tb_top;

    localparam int N    = 64;
    localparam int NREG = N / 32;
    localparam int AW   = $clog2(9 * NREG * 4);
    localparam int G_LVL = 0, G_DIR = 1, G_SET = 2, G_CLR = 3;
    localparam int G_RISE = 4, G_FALL = 5, G_STAT = 6, G_ALT = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_rdata;
    logic [N-1:0]    pad_in = '0;
    logic [N-1:0]    pad_out, pad_oe;
    logic [2*N-1:0]  alt_sel;
    logic            irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [N-1:0] exp_out;
    logic [31:0]  rv;

    always #4 clk = ~clk;

    gpio_ec_ctrl #(.NUM_PINS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .alt_sel(alt_sel), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int ga(input int g, input int w);
        return g * NREG * 4 + w * 4;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R1 during reset
        repeat (3) @(negedge clk);
        chk(pad_oe == 0 && pad_out == 0 && alt_sel == 0 && irq == 0, "R1 in reset",
            {pad_oe, pad_out}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int g = 1; g < 7; g++)
            for (int w = 0; w < NREG; w++) begin
                rd(ga(g, w), rv);
                chk(rv == 0, "R1 register reset", rv, 0);
            end
        for (int k = 0; k < 2 * NREG; k++) begin
            rd(ga(G_ALT, k), rv);
            chk(rv == 0, "R1 alt reset", rv, 0);
        end

        // R2 R4 direction patterns
        for (int p = 0; p < 3; p++) begin
            logic [N-1:0] exp_oe;
            for (int w = 0; w < NREG; w++) begin
                logic [31:0] d;
                d = 32'h9E37_79B9 * (p * 5 + w + 1);
                exp_oe[w*32 +: 32] = d;
                wr(ga(G_DIR, w) + (p & 3), d);
            end
            chk(pad_oe == exp_oe, "R4 pad_oe follows direction", pad_oe, exp_oe);
            for (int w = 0; w < NREG; w++) begin
                rd(ga(G_DIR, w), rv);
                chk(rv == exp_oe[w*32 +: 32], "R2 direction readback", rv, exp_oe[w*32 +: 32]);
            end
        end

        // R5 R6 set/clear sweep
        exp_out = '0;
        for (int p = 0; p < N; p++) begin
            wr(ga(G_SET, p / 32), 32'd1 << (p % 32));
            exp_out[p] = 1'b1;
            chk(pad_out == exp_out, "R5 set one pin", pad_out, exp_out);
        end
        wr(ga(G_SET, 0), 32'd0);
        chk(pad_out == exp_out, "R5 zero set write no change", pad_out, exp_out);
        rd(ga(G_SET, 1), rv);
        chk(rv == 0, "R5 set reads 0", rv, 0);
        for (int p = 0; p < N; p += 2) begin
            wr(ga(G_CLR, p / 32), 32'd1 << (p % 32));
            exp_out[p] = 1'b0;
            chk(pad_out == exp_out, "R6 clear one pin", pad_out, exp_out);
        end
        wr(ga(G_CLR, 1), 32'd0);
        chk(pad_out == exp_out, "R6 zero clear write no change", pad_out, exp_out);
        rd(ga(G_CLR, 0), rv);
        chk(rv == 0, "R6 clear reads 0", rv, 0);

        // R3 level view and latency
        for (int i = 0; i < 4; i++) begin
            logic [N-1:0] pat, old;
            pat = {32'hC3A5_0000 + 32'(i * 977), 32'h1234_5678 ^ 32'(i * 40503)};
            old = pad_in;
            @(negedge clk);
            bus_addr = AW'(ga(G_LVL, 0)); pad_in = pat;
            @(negedge clk); #1;
            chk(bus_rdata == old[31:0], "R3 one clock still old", bus_rdata, old[31:0]);
            @(negedge clk); #1;
            chk(bus_rdata == pat[31:0], "R3 two clocks new", bus_rdata, pat[31:0]);
            rd(ga(G_LVL, 1), rv);
            chk(rv == pat[63:32], "R3 upper word", rv, pat[63:32]);
        end
        begin
            logic [N-1:0] oe_b;
            oe_b = pad_oe;
            wr(ga(G_LVL, 0), 32'hFFFF_FFFF);
            wr(ga(G_LVL, 1), 32'h0);
            chk(pad_out == exp_out && pad_oe == oe_b, "R3 level write ignored", pad_out, exp_out);
        end
        pad_in = '0;
        settle();
        chk(irq == 0, "R11 no enables no irq", irq, 0);

        // R7 R8 R9 R11 rising sweep
        for (int w = 0; w < NREG; w++) begin
            wr(ga(G_RISE, w), 32'hFFFF_FFFF);
            wr(ga(G_FALL, w), 32'h0);
        end
        for (int p = 0; p < N; p++) begin
            @(negedge clk); pad_in[p] = 1'b1;
            settle();
            rd(ga(G_STAT, p / 32), rv);
            chk(rv == (32'd1 << (p % 32)), "R7 rising recorded", rv, 32'd1 << (p % 32));
            chk(irq == 1, "R11 irq with status", irq, 1);
            @(negedge clk); pad_in[p] = 1'b0;
            settle();
            rd(ga(G_STAT, p / 32), rv);
            chk(rv == (32'd1 << (p % 32)), "R8 fall not enabled, status held", rv, 32'd1 << (p % 32));
            wr(ga(G_STAT, p / 32), ~(32'd1 << (p % 32)));
            rd(ga(G_STAT, p / 32), rv);
            chk(rv == (32'd1 << (p % 32)), "R9 zero bits keep status", rv, 32'd1 << (p % 32));
            wr(ga(G_STAT, p / 32), 32'd1 << (p % 32));
            @(negedge clk);
            chk(irq == 0, "R9 write one clears", irq, 0);
        end

        // R8 falling sweep, cleared with all ones
        for (int w = 0; w < NREG; w++) begin
            wr(ga(G_RISE, w), 32'h0);
            wr(ga(G_FALL, w), 32'hFFFF_FFFF);
        end
        for (int p = 0; p < N; p += 3) begin
            @(negedge clk); pad_in[p] = 1'b1;
            settle();
            chk(irq == 0, "R8 rise not enabled", irq, 0);
            @(negedge clk); pad_in[p] = 1'b0;
            settle();
            rd(ga(G_STAT, p / 32), rv);
            chk(rv == (32'd1 << (p % 32)), "R8 falling recorded", rv, 32'd1 << (p % 32));
            wr(ga(G_STAT, p / 32), 32'hFFFF_FFFF);
            @(negedge clk);
            chk(irq == 0, "R9 all ones clears word", irq, 0);
        end

        // R8 both enabled on pin 37
        wr(ga(G_RISE, 1), 32'd1 << 5);
        wr(ga(G_FALL, 1), 32'd1 << 5);
        @(negedge clk); pad_in[37] = 1'b1;
        settle();
        rd(ga(G_STAT, 1), rv);
        chk(rv == (32'd1 << 5), "R8 both: rise recorded", rv, 32'd1 << 5);
        wr(ga(G_STAT, 1), 32'hFFFF_FFFF);
        @(negedge clk); pad_in[37] = 1'b0;
        settle();
        rd(ga(G_STAT, 1), rv);
        chk(rv == (32'd1 << 5), "R8 both: fall recorded", rv, 32'd1 << 5);
        wr(ga(G_STAT, 1), 32'hFFFF_FFFF);

        // R10 edge coincides with clear
        wr(ga(G_RISE, 0), 32'd1);
        wr(ga(G_FALL, 0), 32'd1);
        @(negedge clk); pad_in[0] = 1'b1;
        settle();
        rd(ga(G_STAT, 0), rv);
        chk(rv == 32'd1, "R10 setup status set", rv, 1);
        @(negedge clk); pad_in[0] = 1'b0;
        @(negedge clk);
        @(negedge clk); bus_addr = AW'(ga(G_STAT, 0)); bus_wdata = 32'd1; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        rd(ga(G_STAT, 0), rv);
        chk(rv == 32'd1, "R10 edge wins over same-cycle clear", rv, 1);
        wr(ga(G_STAT, 0), 32'd1);
        rd(ga(G_STAT, 0), rv);
        chk(rv == 32'd0, "R10 later clear works", rv, 0);

        // R12 alternate function fields
        for (int s = 1; s < 3; s++) begin
            logic [2*N-1:0] exp_alt;
            for (int p = 0; p < N; p++) exp_alt[2*p +: 2] = 2'((p * s + s) % 4);
            for (int k = 0; k < 2 * NREG; k++) wr(ga(G_ALT, k), exp_alt[k*32 +: 32]);
            for (int k = 0; k < 2 * NREG; k++) begin
                rd(ga(G_ALT, k), rv);
                chk(rv == exp_alt[k*32 +: 32], "R12 alt readback", rv, exp_alt[k*32 +: 32]);
            end
            for (int p = 0; p < N; p++)
                chk(alt_sel[2*p +: 2] == 2'((p * s + s) % 4), "R12 alt_sel per pin",
                    alt_sel[2*p +: 2], 2'((p * s + s) % 4));
        end

        // R13 unmapped space
        begin
            logic [N-1:0] oe_b;
            logic [2*N-1:0] alt_b;
            oe_b = pad_oe; alt_b = alt_sel;
            rd(ga(9, 0), rv);
            chk(rv == 0, "R13 unmapped reads 0", rv, 0);
            wr(ga(9, 0), 32'hFFFF_FFFF);
            wr(ga(9, 1), 32'hFFFF_FFFF);
            chk(pad_oe == oe_b && pad_out == exp_out && alt_sel == alt_b && irq == 0,
                "R13 unmapped write no effect", pad_out, exp_out);
            rd(ga(G_DIR, 0), rv);
            chk(rv == oe_b[31:0], "R13 direction untouched", rv, oe_b[31:0]);
        end

        summary();
    end

endmodule